// File: doc/BRIEF.md
# Decoupled Execute Engine with Op Replay

This block is the compute side of a processing engine whose address calculation runs in a separate unit. Ops arrive from an op FIFO and name only the kind of work to do. They carry no operand fields. Every operand location comes from one of three address FIFOs: first source, second source and destination. Each is filled by an address generator outside this block. The engine reads the operands from three buffers: an input buffer for the first source, a weight buffer for the second source and an output buffer for the destination. It computes with a small saturating 16-bit ALU and writes the result back to the output buffer at the destination address.

A replay op lets one fetched op run over many data items. The replay count is written into a per-engine count register through a dedicated load port. After a replay op, the next op is popped from the op FIFO once and then executed that many times. Each execution consumes a fresh set of addresses from the FIFOs.

The buffers are assumed to return read data in the same cycle the read address is presented. They write on the clock edge. An op therefore reads, computes and writes back within the cycle in which it issues. Back-to-back accumulations into one address need no forwarding.

Top module: `exec_engine`

## Requirements
- R1: The op code is 3 bits wide: 0 add, 1 mul, 2 mac, 3 pool, 4 act, 5 replay, and 6 and 7 are no-ops. An op has no operand fields; its operands come only from the address FIFOs.
- R2: At most one op issues per cycle. add, mul, mac and pool need the first-source, second-source and destination FIFOs; act needs the first-source and destination FIFOs. An op issues only when all of its FIFOs are non-empty, and it pops all of them in the same cycle.
- R3: An empty address FIFO is never popped, and no buffer access is made with its address.
- R4: While the op FIFO is empty and no replay is in progress, `halt` is high and every buffer read and write enable is low. During a replay that is stalled on addresses, `halt` stays low.
- R5: add writes sat16(a+b) and mul writes sat16(a*b). The operands are 16-bit signed, and sat16 clips to the range -32768..32767.
- R6: mac reads the output buffer at the destination address and writes sat16(d + a*b) back to that same address. The sum is formed at full width before clipping.
- R7: pool writes the signed maximum of a and b. act writes max(a, 0) and neither reads the weight buffer nor pops the second-source FIFO.
- R8: After a replay op, the next op is popped once and executed N times, where N is the count register and N = 0 behaves as 1. The op FIFO is not popped during the replay.
- R9: A count load takes effect from the next cycle. A load made while a replay is running does not change that replay's remaining count.
- R10: After reset, the count register is 0, no replay is armed or running, and nothing is popped or written until ops arrive.
- R11: No-op codes, and a replay op that directly follows a replay op, are popped without consuming addresses or touching any buffer. A repeated replay op leaves the replay armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opq_empty | input | 1 | Op FIFO empty |
| opq_code | input | 3 | Op at the head of the op FIFO |
| opq_pop | output | 1 | Pop the op FIFO |
| srca_empty | input | 1 | First-source address FIFO empty |
| srca_addr | input | AW | First-source address at the head |
| srca_pop | output | 1 | Pop the first-source FIFO |
| srcb_empty | input | 1 | Second-source address FIFO empty |
| srcb_addr | input | AW | Second-source address at the head |
| srcb_pop | output | 1 | Pop the second-source FIFO |
| dst_empty | input | 1 | Destination address FIFO empty |
| dst_addr | input | AW | Destination address at the head |
| dst_pop | output | 1 | Pop the destination FIFO |
| cnt_ld | input | 1 | Load the replay count register |
| cnt_val | input | CW | Replay count to load |
| ibuf_re | output | 1 | Input buffer read enable |
| ibuf_raddr | output | AW | Input buffer read address |
| ibuf_rdata | input | DW | Input buffer read data |
| wbuf_re | output | 1 | Weight buffer read enable |
| wbuf_raddr | output | AW | Weight buffer read address |
| wbuf_rdata | input | DW | Weight buffer read data |
| obuf_re | output | 1 | Output buffer read enable (mac) |
| obuf_raddr | output | AW | Output buffer read address |
| obuf_rdata | input | DW | Output buffer read data |
| obuf_we | output | 1 | Output buffer write enable |
| obuf_waddr | output | AW | Output buffer write address |
| obuf_wdata | output | DW | Output buffer write data |
| halt | output | 1 | No op available; buffers held quiet |

## Verification
The assertions check the FIFO and buffer discipline on every cycle:
- no pop or access on an empty FIFO;
- destination and source pops grouped together;
- a quiet buffer interface while halted;
- mac writing to the address it read;
- act results never negative;
- the replay counter stepping down by one per issued execution with the op FIFO left alone.

Only the bench scenarios can show the following:
- the arithmetic values across the sweep of extreme operands, including saturation;
- the exact number of executions a replay produces;
- that a count load during a replay leaves it unchanged but applies to the next one;
- that no-ops and doubled replay ops leave pending addresses in place.

// File: rtl/exec_pkg.sv
// Shared types for the execute engine: op codes, sequencer states and the
// per-op resource needs. Assumes a 3-bit op code.
package exec_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_MAC  = 3'd2,
        OP_POOL = 3'd3,
        OP_ACT  = 3'd4,
        OP_REP  = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ARMED  = 2'd1,
        SQ_REPLAY = 2'd2
    } seq_e;

    typedef struct packed {
        logic use_a;   // pops first-source FIFO, reads input buffer
        logic use_b;   // pops second-source FIFO, reads weight buffer
        logic use_d;   // pops destination FIFO, writes output buffer
        logic rd_d;    // also reads output buffer at destination
        logic is_rep;  // replay marker
    } need_t;

endpackage

// File: rtl/exec_decode.sv
// Op decoder: maps an op code to the FIFOs and buffer ports it needs.
// Purely combinational; assumes the code encoding of exec_pkg.
module exec_decode
    import exec_pkg::*;
(
    input  logic [2:0] code,
    output need_t      need
);

    // Resource table per op code (R1, R2)
    always_comb begin
        need = '0;
        case (op_e'(code))
            OP_ADD, OP_MUL, OP_POOL: begin
                need.use_a = 1'b1;
                need.use_b = 1'b1;
                need.use_d = 1'b1;
            end
            OP_MAC: begin
                need.use_a = 1'b1;
                need.use_b = 1'b1;
                need.use_d = 1'b1;
                need.rd_d  = 1'b1;
            end
            OP_ACT: begin
                need.use_a = 1'b1;
                need.use_d = 1'b1;
            end
            OP_REP:  need.is_rep = 1'b1;
            default: need = '0;
        endcase
    end

endmodule

// File: rtl/exec_alu.sv
// Saturating signed ALU: add, multiply, multiply-accumulate, max and ReLU.
// Intermediate results are formed at full width and clipped to DW bits.
module exec_alu
    import exec_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]           code,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic signed [DW-1:0] d,
    output logic signed [DW-1:0] res
);

    localparam int PW = 2 * DW;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] ax, bx, dx, px;

    // Clip a wide signed value to the DW-bit range
    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] x);
        if (x > MAXV)      return MAXV[DW-1:0];
        else if (x < MINV) return MINV[DW-1:0];
        else               return x[DW-1:0];
    endfunction

    // Sign-extend operands and form the full product
    always_comb begin
        prod = a * b;
        ax   = {{(SW-DW){a[DW-1]}}, a};
        bx   = {{(SW-DW){b[DW-1]}}, b};
        dx   = {{(SW-DW){d[DW-1]}}, d};
        px   = {{(SW-PW){prod[PW-1]}}, prod};
    end

    // Select the result for the op
    always_comb begin
        case (op_e'(code))
            OP_ADD:  res = clip(ax + bx);
            OP_MUL:  res = clip(px);
            OP_MAC:  res = clip(dx + px);
            OP_POOL: res = (a > b) ? a : b;
            OP_ACT:  res = a[DW-1] ? '0 : a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/exec_seq.sv
// Issue sequencer: chooses the current op (FIFO head or the replayed op),
// decides issue from address-FIFO readiness, and runs the replay counter.
// Assumes the needs of cur_code are decoded outside and fed back as 'need'.
module exec_seq
    import exec_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          opq_empty,
    input  logic [2:0]    opq_code,
    input  need_t         need,
    input  logic          srca_empty,
    input  logic          srcb_empty,
    input  logic          dst_empty,
    input  logic          cnt_ld,
    input  logic [CW-1:0] cnt_val,
    output logic [2:0]    cur_code,
    output logic          fire,
    output logic          opq_pop,
    output logic          halt,
    output seq_e          state,
    output logic [CW-1:0] rem
);

    logic [CW-1:0] rep_reg;
    logic [CW-1:0] eff_n;
    logic [2:0]    held;
    logic          cur_vld;
    logic          addr_ok;

    // Current op source and issue decision
    always_comb begin
        cur_vld  = (state == SQ_REPLAY) || !opq_empty;
        cur_code = (state == SQ_REPLAY) ? held : opq_code;
        addr_ok  = (!need.use_a || !srca_empty) &&
                   (!need.use_b || !srcb_empty) &&
                   (!need.use_d || !dst_empty);
        fire     = cur_vld && addr_ok;
        opq_pop  = fire && (state != SQ_REPLAY);
        halt     = !cur_vld;
        eff_n    = (rep_reg == '0) ? CW'(1) : rep_reg;
    end

    // Replay count register, written only through the load port
    always_ff @(posedge clk) begin
        if (!rst_n)      rep_reg <= '0;
        else if (cnt_ld) rep_reg <= cnt_val;
    end

    // Replay state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            rem   <= '0;
            held  <= 3'd0;
        end else if (fire) begin
            case (state)
                SQ_IDLE: begin
                    if (need.is_rep) state <= SQ_ARMED;
                end
                SQ_ARMED: begin
                    if (!need.is_rep) begin
                        if (eff_n > CW'(1)) begin
                            held  <= cur_code;
                            rem   <= eff_n - CW'(1);
                            state <= SQ_REPLAY;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                end
                SQ_REPLAY: begin
                    if (rem == CW'(1)) begin
                        rem   <= '0;
                        state <= SQ_IDLE;
                    end else begin
                        rem <= rem - CW'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/exec_engine.sv
// Execute engine top: pops address-free ops, takes operand addresses from
// three address FIFOs, reads the buffers, computes and writes the result.
// Assumes buffers with same-cycle read data and edge-triggered writes.
module exec_engine
    import exec_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          opq_empty,
    input  logic [2:0]    opq_code,
    output logic          opq_pop,
    input  logic          srca_empty,
    input  logic [AW-1:0] srca_addr,
    output logic          srca_pop,
    input  logic          srcb_empty,
    input  logic [AW-1:0] srcb_addr,
    output logic          srcb_pop,
    input  logic          dst_empty,
    input  logic [AW-1:0] dst_addr,
    output logic          dst_pop,
    input  logic          cnt_ld,
    input  logic [CW-1:0] cnt_val,
    output logic          ibuf_re,
    output logic [AW-1:0] ibuf_raddr,
    input  logic [DW-1:0] ibuf_rdata,
    output logic          wbuf_re,
    output logic [AW-1:0] wbuf_raddr,
    input  logic [DW-1:0] wbuf_rdata,
    output logic          obuf_re,
    output logic [AW-1:0] obuf_raddr,
    input  logic [DW-1:0] obuf_rdata,
    output logic          obuf_we,
    output logic [AW-1:0] obuf_waddr,
    output logic [DW-1:0] obuf_wdata,
    output logic          halt
);

    logic [2:0]           cur_code;
    need_t                need;
    logic                 fire;
    seq_e                 seq_state;
    logic [CW-1:0]        seq_rem;
    logic signed [DW-1:0] alu_res;

    exec_decode u_dec (
        .code (cur_code),
        .need (need)
    );

    exec_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .opq_empty  (opq_empty),
        .opq_code   (opq_code),
        .need       (need),
        .srca_empty (srca_empty),
        .srcb_empty (srcb_empty),
        .dst_empty  (dst_empty),
        .cnt_ld     (cnt_ld),
        .cnt_val    (cnt_val),
        .cur_code   (cur_code),
        .fire       (fire),
        .opq_pop    (opq_pop),
        .halt       (halt),
        .state      (seq_state),
        .rem        (seq_rem)
    );

    exec_alu #(.DW(DW)) u_alu (
        .code (cur_code),
        .a    (ibuf_rdata),
        .b    (wbuf_rdata),
        .d    (obuf_rdata),
        .res  (alu_res)
    );

    // Address pops and buffer strobes follow the issue decision
    always_comb begin
        srca_pop   = fire && need.use_a;
        srcb_pop   = fire && need.use_b;
        dst_pop    = fire && need.use_d;
        ibuf_re    = srca_pop;
        ibuf_raddr = srca_addr;
        wbuf_re    = srcb_pop;
        wbuf_raddr = srcb_addr;
        obuf_re    = fire && need.rd_d;
        obuf_raddr = dst_addr;
        obuf_we    = dst_pop;
        obuf_waddr = dst_addr;
        obuf_wdata = alu_res;
    end

endmodule

// File: rtl/exec_engine_chk.sv
// Assertion checker for exec_engine, attached by bind. Observes ports and
// the sequencer state; holds no state of its own beyond $past.
module exec_engine_chk
    import exec_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          opq_pop,
    input logic          srca_empty,
    input logic          srca_pop,
    input logic          srcb_empty,
    input logic          srcb_pop,
    input logic          dst_empty,
    input logic          dst_pop,
    input logic          ibuf_re,
    input logic          wbuf_re,
    input logic          obuf_re,
    input logic [AW-1:0] obuf_raddr,
    input logic          obuf_we,
    input logic [AW-1:0] obuf_waddr,
    input logic [DW-1:0] obuf_wdata,
    input logic          halt,
    input logic          fire,
    input logic [1:0]    seq_state,
    input logic [CW-1:0] seq_rem
);

    p_srca_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srca_empty |-> (!srca_pop && !ibuf_re));

    p_srcb_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srcb_empty |-> (!srcb_pop && !wbuf_re));

    p_dst_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dst_empty |-> (!dst_pop && !obuf_we && !obuf_re));

    p_pop_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srcb_pop || dst_pop) |-> srca_pop);

    p_dst_with_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        srca_pop |-> dst_pop);

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!ibuf_re && !wbuf_re && !obuf_re && !obuf_we && !opq_pop));

    p_mac_inplace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_re |-> (obuf_we && (obuf_waddr == obuf_raddr) && srcb_pop));

    p_relu_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (obuf_we && !wbuf_re) |-> !obuf_wdata[DW-1]);

    p_replay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_REPLAY) |-> !opq_pop);

    p_replay_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_REPLAY && fire && seq_rem != CW'(1)) |=>
        (seq_state == SQ_REPLAY && seq_rem == $past(seq_rem) - CW'(1)));

    p_replay_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_REPLAY && fire && seq_rem == CW'(1)) |=>
        (seq_state == SQ_IDLE));

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seq_state == SQ_IDLE && seq_rem == '0));

endmodule

bind exec_engine exec_engine_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opq_pop    (opq_pop),
    .srca_empty (srca_empty),
    .srca_pop   (srca_pop),
    .srcb_empty (srcb_empty),
    .srcb_pop   (srcb_pop),
    .dst_empty  (dst_empty),
    .dst_pop    (dst_pop),
    .ibuf_re    (ibuf_re),
    .wbuf_re    (wbuf_re),
    .obuf_re    (obuf_re),
    .obuf_raddr (obuf_raddr),
    .obuf_we    (obuf_we),
    .obuf_waddr (obuf_waddr),
    .obuf_wdata (obuf_wdata),
    .halt       (halt),
    .fire       (fire),
    .seq_state  (seq_state),
    .seq_rem    (seq_rem)
);

// File: tb/sim_exec_engine.sv
`timescale 1ns/1ps
// Bench for exec_engine: models the op FIFO, three address FIFOs and three
// buffers; sweeps all ops over an 8-value operand set and exercises replay.
module sim_exec_engine;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          opq_empty, opq_pop;
    logic [2:0]    opq_code;
    logic          srca_empty, srca_pop, srcb_empty, srcb_pop, dst_empty, dst_pop;
    logic [AW-1:0] srca_addr, srcb_addr, dst_addr;
    logic          cnt_ld = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic          ibuf_re, wbuf_re, obuf_re, obuf_we, halt;
    logic [AW-1:0] ibuf_raddr, wbuf_raddr, obuf_raddr, obuf_waddr;
    logic [DW-1:0] ibuf_rdata, wbuf_rdata, obuf_rdata, obuf_wdata;

    logic [2:0]           op_q [0:1023];
    logic [AW-1:0]        a_q  [0:2047];
    logic [AW-1:0]        b_q  [0:2047];
    logic [AW-1:0]        d_q  [0:2047];
    logic signed [DW-1:0] inbuf  [0:255];
    logic signed [DW-1:0] wtbuf  [0:255];
    logic signed [DW-1:0] outbuf [0:255];

    int op_wr = 0, op_rd = 0, a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0, d_wr = 0, d_rd = 0;
    int wr_cnt = 0;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_data = '0;

    int vals [0:7] = '{-32768, -200, -1, 0, 1, 3, 181, 32767};
    int total = 0, bad = 0;
    logic timed_out = 1'b0;

    assign opq_empty  = (op_rd == op_wr);
    assign opq_code   = op_q[op_rd[9:0]];
    assign srca_empty = (a_rd == a_wr);
    assign srcb_empty = (b_rd == b_wr);
    assign dst_empty  = (d_rd == d_wr);
    assign srca_addr  = a_q[a_rd[10:0]];
    assign srcb_addr  = b_q[b_rd[10:0]];
    assign dst_addr   = d_q[d_rd[10:0]];
    assign ibuf_rdata = inbuf[ibuf_raddr];
    assign wbuf_rdata = wtbuf[wbuf_raddr];
    assign obuf_rdata = outbuf[obuf_raddr];

    exec_engine #(.DW(DW), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .opq_empty(opq_empty), .opq_code(opq_code), .opq_pop(opq_pop),
        .srca_empty(srca_empty), .srca_addr(srca_addr), .srca_pop(srca_pop),
        .srcb_empty(srcb_empty), .srcb_addr(srcb_addr), .srcb_pop(srcb_pop),
        .dst_empty(dst_empty), .dst_addr(dst_addr), .dst_pop(dst_pop),
        .cnt_ld(cnt_ld), .cnt_val(cnt_val),
        .ibuf_re(ibuf_re), .ibuf_raddr(ibuf_raddr), .ibuf_rdata(ibuf_rdata),
        .wbuf_re(wbuf_re), .wbuf_raddr(wbuf_raddr), .wbuf_rdata(wbuf_rdata),
        .obuf_re(obuf_re), .obuf_raddr(obuf_raddr), .obuf_rdata(obuf_rdata),
        .obuf_we(obuf_we), .obuf_waddr(obuf_waddr), .obuf_wdata(obuf_wdata),
        .halt(halt)
    );

    // FIFO read pointers, output buffer writes and write counter
    always @(posedge clk) begin
        if (opq_pop)  op_rd <= op_rd + 1;
        if (srca_pop) a_rd  <= a_rd + 1;
        if (srcb_pop) b_rd  <= b_rd + 1;
        if (dst_pop)  d_rd  <= d_rd + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) outbuf[i] <= '0;
        end else if (obuf_we) begin
            outbuf[obuf_waddr] <= obuf_wdata;
            wr_cnt <= wr_cnt + 1;
        end else if (pre_we) begin
            outbuf[pre_addr] <= pre_data;
        end
    end

    function automatic longint sat(input longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_op(input int code);
        op_q[op_wr[9:0]] = 3'(code);
        op_wr++;
    endtask

    task automatic push_a(input int x); a_q[a_wr[10:0]] = AW'(x); a_wr++; endtask
    task automatic push_b(input int x); b_q[b_wr[10:0]] = AW'(x); b_wr++; endtask
    task automatic push_d(input int x); d_q[d_wr[10:0]] = AW'(x); d_wr++; endtask

    task automatic push_set(input int a, input int b, input int d);
        push_a(a); push_b(b); push_d(d);
    endtask

    task automatic preset(input int addr, input int v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = AW'(addr); pre_data = DW'(v);
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic load_cnt(input int v);
        @(negedge clk);
        cnt_ld = 1'b1; cnt_val = CW'(v);
        @(negedge clk);
        cnt_ld = 1'b0;
    endtask

    task automatic drain;
        @(negedge clk);
        while (!halt) @(negedge clk);
    endtask

    // Sweep a two-source op over all operand pairs into base..base+63
    task automatic sweep2(input int code, input int base, input string req);
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                push_op(code);
                push_set(i, j, base + i*8 + j);
            end
        drain();
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                longint e;
                longint va = vals[i];
                longint vb = vals[j];
                case (code)
                    0: e = sat(va + vb);
                    1: e = sat(va * vb);
                    2: e = sat(longint'(vals[(i+j)%8]) + va * vb);
                    default: e = (va > vb) ? va : vb;
                endcase
                chk(req, longint'(outbuf[base + i*8 + j]), e);
            end
    endtask

    task automatic run_tests;
        int op0, a0, b0, w0;
        longint acc;
        for (int i = 0; i < 8; i++) begin
            inbuf[i] = DW'(vals[i]);
            wtbuf[i] = DW'(vals[i]);
        end
        repeat (3) @(negedge clk);
        // R10 / R4: quiet during and after reset
        chk("R10 halt in reset", longint'(halt), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 halt after reset", longint'(halt), 1);
        chk("R4 no write when halted", longint'(obuf_we), 0);
        chk("R4 no read when halted", longint'(ibuf_re | wbuf_re | obuf_re), 0);
        chk("R10 no pop after reset", longint'(opq_pop), 0);

        // R5 add and mul, R7 pool, R1 codes 0..3
        sweep2(0, 0,   "R5 add");
        sweep2(1, 64,  "R5 mul");
        sweep2(3, 128, "R7 pool");
        // R6 mac: preset destination then accumulate
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) preset(192 + i*8 + j, vals[(i+j)%8]);
        sweep2(2, 192, "R6 mac");

        // R7 act with a stray second-source address pending
        push_b(5);
        b0 = b_rd;
        for (int i = 0; i < 8; i++) begin
            push_op(4);
            push_a(i);
            push_d(i);
        end
        drain();
        for (int i = 0; i < 8; i++)
            chk("R7 act relu", longint'(outbuf[i]), (vals[i] > 0) ? vals[i] : 0);
        chk("R7 act leaves srcb fifo", b_rd, b0);
        // the stray address now serves an add
        push_op(0); push_a(4); push_d(9);
        drain();
        chk("R2 add uses pending srcb", longint'(outbuf[9]), 4);

        // R2 / R3 stall on a missing second-source address
        op0 = op_rd; a0 = a_rd; w0 = wr_cnt;
        push_op(0); push_a(2); push_d(10);
        repeat (5) @(negedge clk);
        chk("R2 op waits for srcb", op_rd, op0);
        chk("R3 srca not popped while srcb empty", a_rd, a0);
        chk("R3 no write while stalled", wr_cnt, w0);
        push_b(5);
        drain();
        chk("R2 add after srcb arrives", longint'(outbuf[10]), sat(vals[2] + vals[5]));

        // R8 replay of mac, four executions, then two plain acts
        load_cnt(4);
        preset(20, 5);
        op0 = op_rd; w0 = wr_cnt;
        push_op(5);
        repeat (3) @(negedge clk);
        chk("R4 halt while armed and op fifo empty", longint'(halt), 1);
        push_op(2);
        for (int k = 4; k < 8; k++) push_set(5, k, 20);
        push_op(4); push_a(1); push_d(21);
        push_op(4); push_a(6); push_d(22);
        drain();
        acc = 5;
        for (int k = 4; k < 8; k++) acc = sat(acc + longint'(vals[5]) * vals[k]);
        chk("R8 replayed mac result", longint'(outbuf[20]), acc);
        chk("R8 op fifo popped once per op", op_rd - op0, 4);
        chk("R8 write count", wr_cnt - w0, 6);
        chk("R8 act after replay", longint'(outbuf[21]), 0);
        chk("R8 second act", longint'(outbuf[22]), 181);

        // R8 count 0 behaves as one execution
        load_cnt(0);
        w0 = wr_cnt;
        push_op(5);
        push_op(0); push_set(4, 4, 30);
        push_op(0); push_set(5, 5, 31);
        drain();
        chk("R8 zero count runs once", wr_cnt - w0, 2);
        chk("R8 zero count add", longint'(outbuf[30]), 2);
        chk("R8 following add", longint'(outbuf[31]), 6);

        // R9 load during a stalled replay does not change it
        load_cnt(3);
        w0 = wr_cnt;
        push_op(5);
        push_op(0); push_set(4, 5, 40);
        repeat (4) @(negedge clk);
        chk("R4 halt low during stalled replay", longint'(halt), 0);
        load_cnt(6);
        push_set(5, 5, 41);
        push_set(6, 4, 42);
        push_op(4); push_a(6); push_d(43);
        drain();
        chk("R9 replay keeps old count", wr_cnt - w0, 4);
        chk("R9 replay add 3", longint'(outbuf[42]), 182);
        chk("R9 act after replay", longint'(outbuf[43]), 181);
        // the new count applies to the next replay
        w0 = wr_cnt;
        push_op(5);
        push_op(4);
        for (int k = 0; k < 6; k++) begin push_a(k + 2); push_d(50 + k); end
        drain();
        chk("R9 new count used", wr_cnt - w0, 6);
        chk("R9 last replayed act", longint'(outbuf[55]), 32767);

        // R11 no-ops leave pending addresses untouched
        load_cnt(1);
        push_a(7); push_d(60);
        a0 = a_rd; op0 = op_rd; w0 = wr_cnt;
        push_op(6); push_op(7);
        drain();
        chk("R11 nops popped", op_rd - op0, 2);
        chk("R11 nops take no address", a_rd, a0);
        chk("R11 nops write nothing", wr_cnt, w0);
        push_op(5); push_op(5); push_op(4);
        drain();
        chk("R11 double replay then act", longint'(outbuf[60]), 32767);
        chk("R11 single write", wr_cnt - w0, 1);
        chk("R1 all ops consumed", op_wr - op_rd, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (60000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule